// File: doc/BRIEF.md
# Pass-Window Edge Search Engine

This block takes the pass/fail result of a delay sweep, one bit per delay setting from 0 to 255, and finds the window of settings that pass. A bit of 1 means the setting passed. The search looks for a rising edge, where a fail turns into a pass. It then looks for a falling edge, where a pass turns into a fail. Each edge must be backed by several neighbouring samples that agree, so a lone stray bit does not count as an edge. From the two edge indices the block derives a delay setting. When no usable window exists, it reports a default value that the caller supplies.

The vector is loaded before a scan. It can be loaded all at once, or shifted in one bit per clock. A start pulse then launches the scan. The scan examines one index per clock and ends with a one-cycle done pulse. The results stay unchanged until the next scan ends. Driving the sweep itself is left to the surrounding logic.

Top module: `pw_edge_search`

## Requirements
- R1: After reset, done_o and found_o are 0, win_min_o and win_max_o are all ones (-1 in 9-bit two's complement), and delay_o is 0.
- R2: A parallel load writes par_vec_i into the vector, with bit k standing for delay setting k. Each serial enable shifts ser_bit_i into index 255 and moves every other bit down by one index, so after 256 shifts the first bit sent sits at index 0. A parallel load wins over a serial shift in the same cycle.
- R3: A rising edge is accepted at index i when bit i is 1, bit i-1 is 0, and bits i+1, i+2 and i+3 are 1. Only indices 4 to 251 are examined, and the lowest accepted index becomes win_min_o.
- R4: A falling edge is accepted at index i when bit i is 0 and bits i-1, i-2 and i-3 are 1. The falling search runs from the rising index up to 251, and the lowest accepted index becomes win_max_o. A single 0 inside a run of 1s is therefore accepted as a falling edge.
- R5: An edge that is not found is reported as all ones. If no rising edge is found, no falling search takes place and both indices read all ones.
- R6: When both edges are found, found_o is 1 and delay_o equals (win_max_o - win_min_o) / 2, rounded down.
- R7: When either edge is missing, or the halved difference is not positive, found_o is 0 and delay_o equals dflt_i as sampled on the clock edge that raises done_o.
- R8: The scan examines one index per clock, and the rising index is examined again as the first step of the falling search. If the start pulse is sampled on edge E0 and N indices are examined, done_o is high after edge E(N+1).
- R9: done_o is high for exactly one cycle. The result outputs change only together with done_o and hold their values until the next scan completes.
- R10: A start pulse that arrives while a scan is running has no effect on that scan's timing or results.
- R11: Parallel and serial loads are ignored from the start edge until the scan finishes. The stored vector is kept after the scan, so a new start without a reload gives the same results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a scan when the block is idle |
| par_ld_i | input | 1 | Parallel load strobe |
| par_vec_i | input | 256 | Vector for a parallel load, bit k = setting k |
| ser_en_i | input | 1 | Serial shift enable |
| ser_bit_i | input | 1 | Serial data bit |
| dflt_i | input | 8 | Fallback delay value |
| win_min_o | output | 9 | Rising-edge index, all ones if not found |
| win_max_o | output | 9 | Falling-edge index, all ones if not found |
| found_o | output | 1 | A valid window was found |
| delay_o | output | 8 | Chosen delay setting |
| done_o | output | 1 | One-cycle pulse when the results update |

## Verification
The engine is tried with several kinds of vector.

- A clean window shows the basic search and the halving of the difference.
- A vector with a lone 1, a two-bit pulse and a single 0 inside the window shows which disturbances the filter rejects and which it accepts.
- An all-zero vector, a window that runs to index 255 and a window that begins at index 0 each force the fallback, each for a different reason.
- Windows whose rising edge falls exactly at index 4 or whose falling edge falls exactly at 251 probe the ends of the search range.
- A window that begins at 252 checks that indices past the limit are never examined.
- One scan receives a second start and a new parallel load while it runs. A later scan without a reload then confirms that the stored vector was kept.

Since the finishing cycle depends on where the edges lie, the done pulse and the held outputs are compared against a model on every clock.

// File: rtl/pw_pkg.sv
package pw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RISE = 2'd1,
    ST_FALL = 2'd2,
    ST_FIN  = 2'd3
  } pw_state_e;
endpackage

// File: rtl/pw_vec_store.sv
module pw_vec_store #(
  parameter int VEC_LEN = 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lock_i,
  input  logic               par_ld_i,
  input  logic [VEC_LEN-1:0] par_vec_i,
  input  logic               ser_en_i,
  input  logic               ser_bit_i,
  output logic [VEC_LEN-1:0] vec_o
);
  logic [VEC_LEN-1:0] vec_q, vec_n;
  logic               vec_en;

  always_comb begin
    vec_en = !lock_i && (par_ld_i || ser_en_i);
    if (par_ld_i) vec_n = par_vec_i;
    else          vec_n = {ser_bit_i, vec_q[VEC_LEN-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vec_q <= '0;
    else if (vec_en) vec_q <= vec_n;
  end

  assign vec_o = vec_q;

  // R11: the vector is frozen while a scan holds the lock
  a_r11_vec_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    lock_i |=> $stable(vec_q));
  // R2: a parallel load while unlocked lands in the store
  a_r2_par_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_i && par_ld_i) |=> vec_q == $past(par_vec_i));
endmodule

// File: rtl/pw_edge_qual.sv
module pw_edge_qual #(
  parameter int VEC_LEN = 256,
  parameter int IDX_W   = 8,
  parameter int NSAMP   = 4
) (
  input  logic [VEC_LEN-1:0] vec_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic               rise_o,
  output logic               fall_o
);
  localparam int CTR  = NSAMP - 1;
  localparam int TAPS = 2 * NSAMP - 1;

  logic [TAPS-1:0] tap;

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    logic [IDX_W-1:0] pos;
    assign pos    = idx_i + IDX_W'(k) - IDX_W'(CTR);
    assign tap[k] = vec_i[pos];
  end

  // rising: centre 1, one below 0, NSAMP-1 above all 1
  assign rise_o = tap[CTR] & ~tap[CTR-1] & (&tap[TAPS-1:CTR+1]);
  // falling: centre 0, NSAMP-1 below all 1
  assign fall_o = ~tap[CTR] & (&tap[CTR-1:0]);

  // R3/R4: a position cannot be both edge kinds at once
  always_comb begin
    a_r3_r4_exclusive: assert (!(rise_o && fall_o));
  end
endmodule

// File: rtl/pw_scan_ctrl.sv
module pw_scan_ctrl
  import pw_pkg::*;
#(
  parameter int IDX_W     = 8,
  parameter int START_IDX = 4,
  parameter int LIMIT_IDX = 251
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             rise_i,
  input  logic             fall_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             busy_o,
  output logic             fin_o,
  output logic             min_hit_o,
  output logic             max_hit_o,
  output logic [IDX_W-1:0] min_idx_o,
  output logic [IDX_W-1:0] max_idx_o
);
  localparam logic [IDX_W-1:0] START_C = IDX_W'(START_IDX);
  localparam logic [IDX_W-1:0] LIMIT_C = IDX_W'(LIMIT_IDX);

  pw_state_e        state_q, state_n;
  logic [IDX_W-1:0] idx_q, idx_n, min_q, min_n, max_q, max_n;
  logic             min_hit_q, min_hit_n, max_hit_q, max_hit_n;
  logic             at_limit;

  always_comb begin
    state_n   = state_q;
    idx_n     = idx_q;
    min_n     = min_q;
    max_n     = max_q;
    min_hit_n = min_hit_q;
    max_hit_n = max_hit_q;
    at_limit  = (idx_q == LIMIT_C);
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_n   = ST_RISE;
        idx_n     = START_C;
        min_hit_n = 1'b0;
        max_hit_n = 1'b0;
      end
      ST_RISE: begin
        if (rise_i) begin
          min_n     = idx_q;
          min_hit_n = 1'b1;
          state_n   = ST_FALL;
        end else if (at_limit) begin
          state_n = ST_FIN;
        end else begin
          idx_n = idx_q + 1'b1;
        end
      end
      ST_FALL: begin
        if (fall_i) begin
          max_n     = idx_q;
          max_hit_n = 1'b1;
          state_n   = ST_FIN;
        end else if (at_limit) begin
          state_n = ST_FIN;
        end else begin
          idx_n = idx_q + 1'b1;
        end
      end
      ST_FIN: state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      min_q     <= '0;
      max_q     <= '0;
      min_hit_q <= 1'b0;
      max_hit_q <= 1'b0;
    end else begin
      state_q   <= state_n;
      idx_q     <= idx_n;
      min_q     <= min_n;
      max_q     <= max_n;
      min_hit_q <= min_hit_n;
      max_hit_q <= max_hit_n;
    end
  end

  assign idx_o     = idx_q;
  assign busy_o    = (state_q != ST_IDLE);
  assign fin_o     = (state_q == ST_FIN);
  assign min_hit_o = min_hit_q;
  assign max_hit_o = max_hit_q;
  assign min_idx_o = min_q;
  assign max_idx_o = max_q;

  // R3: the examined index stays inside the search range
  a_r3_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RISE || state_q == ST_FALL) |->
      (idx_q >= START_C && idx_q <= LIMIT_C));
  // R4: the falling search begins at the rising index
  a_r4_fall_from_min: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RISE && rise_i) |=> (state_q == ST_FALL && idx_q == $past(idx_q)));
  // R10: a start during a scan never restarts it
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && start_i) |=> !(state_q == ST_RISE && idx_q == START_C));
  // R5: the falling hit needs a rising hit first
  a_r5_max_needs_min: assert property (@(posedge clk) disable iff (!rst_n)
    max_hit_q |-> min_hit_q);
endmodule

// File: rtl/pw_result.sv
module pw_result #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fin_i,
  input  logic             min_hit_i,
  input  logic             max_hit_i,
  input  logic [IDX_W-1:0] min_idx_i,
  input  logic [IDX_W-1:0] max_idx_i,
  input  logic [IDX_W-1:0] dflt_i,
  output logic [IDX_W:0]   win_min_o,
  output logic [IDX_W:0]   win_max_o,
  output logic             found_o,
  output logic [IDX_W-1:0] delay_o,
  output logic             done_o
);
  logic [IDX_W:0]   diff, min_n, max_n, min_q, max_q;
  logic [IDX_W-1:0] half, dly_n, dly_q;
  logic             ok, found_q, done_q;

  always_comb begin
    diff  = {1'b0, max_idx_i} - {1'b0, min_idx_i};
    half  = diff[IDX_W:1];
    ok    = min_hit_i && max_hit_i && !diff[IDX_W] && (half != '0);
    dly_n = ok ? half : dflt_i;
    min_n = min_hit_i ? {1'b0, min_idx_i} : '1;
    max_n = max_hit_i ? {1'b0, max_idx_i} : '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      min_q   <= '1;
      max_q   <= '1;
      found_q <= 1'b0;
      dly_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= fin_i;
      if (fin_i) begin
        min_q   <= min_n;
        max_q   <= max_n;
        found_q <= ok;
        dly_q   <= dly_n;
      end
    end
  end

  assign win_min_o = min_q;
  assign win_max_o = max_q;
  assign found_o   = found_q;
  assign delay_o   = dly_q;
  assign done_o    = done_q;

  // R9: done lasts a single cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R9: results hold unless a finish is being recorded
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fin_i |=> ($stable(dly_q) && $stable(found_q) && $stable(min_q) && $stable(max_q)));
  // R7: fallback reports the default seen at the finishing edge
  a_r7_default: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !found_q) |-> dly_q == $past(dflt_i));
  // R6: a found window has its falling index above the rising one
  a_r6_order: assert property (@(posedge clk) disable iff (!rst_n)
    found_q |-> (max_q > min_q));
endmodule

// File: rtl/pw_edge_search.sv
module pw_edge_search #(
  parameter int VEC_LEN = 256,
  parameter int NSAMP   = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic                       par_ld_i,
  input  logic [VEC_LEN-1:0]         par_vec_i,
  input  logic                       ser_en_i,
  input  logic                       ser_bit_i,
  input  logic [$clog2(VEC_LEN)-1:0] dflt_i,
  output logic [$clog2(VEC_LEN):0]   win_min_o,
  output logic [$clog2(VEC_LEN):0]   win_max_o,
  output logic                       found_o,
  output logic [$clog2(VEC_LEN)-1:0] delay_o,
  output logic                       done_o
);
  localparam int IDX_W     = $clog2(VEC_LEN);
  localparam int START_IDX = NSAMP;
  localparam int LIMIT_IDX = VEC_LEN - 1 - NSAMP;

  logic [VEC_LEN-1:0] vec;
  logic [IDX_W-1:0]   idx, min_idx, max_idx;
  logic               rise, fall, busy, fin, min_hit, max_hit;

  pw_vec_store #(.VEC_LEN(VEC_LEN)) u_store (
    .clk(clk), .rst_n(rst_n), .lock_i(busy),
    .par_ld_i(par_ld_i), .par_vec_i(par_vec_i),
    .ser_en_i(ser_en_i), .ser_bit_i(ser_bit_i), .vec_o(vec)
  );

  pw_edge_qual #(.VEC_LEN(VEC_LEN), .IDX_W(IDX_W), .NSAMP(NSAMP)) u_qual (
    .vec_i(vec), .idx_i(idx), .rise_o(rise), .fall_o(fall)
  );

  pw_scan_ctrl #(.IDX_W(IDX_W), .START_IDX(START_IDX), .LIMIT_IDX(LIMIT_IDX)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .rise_i(rise), .fall_i(fall), .idx_o(idx), .busy_o(busy), .fin_o(fin),
    .min_hit_o(min_hit), .max_hit_o(max_hit),
    .min_idx_o(min_idx), .max_idx_o(max_idx)
  );

  pw_result #(.IDX_W(IDX_W)) u_res (
    .clk(clk), .rst_n(rst_n), .fin_i(fin),
    .min_hit_i(min_hit), .max_hit_i(max_hit),
    .min_idx_i(min_idx), .max_idx_i(max_idx), .dflt_i(dflt_i),
    .win_min_o(win_min_o), .win_max_o(win_max_o),
    .found_o(found_o), .delay_o(delay_o), .done_o(done_o)
  );
endmodule

// File: tb/pw_edge_search_tb_top.sv
module pw_edge_search_tb_top;
  timeunit 1ns; timeprecision 1ps;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start_i, par_ld_i, ser_en_i, ser_bit_i;
  logic [255:0] par_vec_i;
  logic [7:0]   dflt_i, delay_o;
  logic [8:0]   win_min_o, win_max_o;
  logic         found_o, done_o;

  int checks = 0;
  int fails  = 0;
  int prev_min = -1, prev_max = -1, prev_dly = 0, prev_fnd = 0;

  always #4 clk = ~clk;

  pw_edge_search dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .par_ld_i(par_ld_i),
    .par_vec_i(par_vec_i), .ser_en_i(ser_en_i), .ser_bit_i(ser_bit_i),
    .dflt_i(dflt_i), .win_min_o(win_min_o), .win_max_o(win_max_o),
    .found_o(found_o), .delay_o(delay_o), .done_o(done_o)
  );

  function automatic logic [255:0] mkwin(int lo, int hi);
    logic [255:0] v = '0;
    for (int i = lo; i <= hi; i++) v[i] = 1'b1;
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare all result outputs with expected values
  task automatic chk_outs(input string req, input int mn, input int mx,
                          input int fnd, input int dly);
    chk(int'($signed(win_min_o)) == mn, req, "win_min", int'($signed(win_min_o)), mn);
    chk(int'($signed(win_max_o)) == mx, req, "win_max", int'($signed(win_max_o)), mx);
    chk(int'(found_o) == fnd, req, "found", int'(found_o), fnd);
    chk(int'(delay_o) == dly, req, "delay", int'(delay_o), dly);
  endtask

  // behavioural reference: edges and number of examined indices
  task automatic model(input logic [255:0] v, output int mn, output int mx, output int n);
    mn = -1; mx = -1; n = 0;
    for (int i = 4; i <= 251; i++) begin
      n++;
      if (v[i] && !v[i-1] && v[i+1] && v[i+2] && v[i+3]) begin mn = i; break; end
    end
    if (mn >= 0)
      for (int i = mn; i <= 251; i++) begin
        n++;
        if (!v[i] && v[i-1] && v[i-2] && v[i-3]) begin mx = i; break; end
      end
  endtask

  task automatic par_load(input logic [255:0] v);
    @(negedge clk); par_ld_i = 1'b1; par_vec_i = v;
    @(negedge clk); par_ld_i = 1'b0;
  endtask

  task automatic ser_load(input logic [255:0] v);
    for (int k = 0; k < 256; k++) begin
      @(negedge clk); ser_en_i = 1'b1; ser_bit_i = v[k];
    end
    @(negedge clk); ser_en_i = 1'b0; ser_bit_i = 1'b0;
  endtask

  task automatic run_scan(input string req, input logic [255:0] v, input int dflt,
                          input bit inject);
    int mn, mx, n, fnd, dly;
    model(v, mn, mx, n);
    if (mn >= 0 && mx >= 0 && (mx - mn) / 2 > 0) begin fnd = 1; dly = (mx - mn) / 2; end
    else begin fnd = 0; dly = dflt; end
    @(negedge clk); dflt_i = 8'(dflt); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    for (int k = 1; k <= 400; k++) begin
      @(negedge clk);
      start_i  = 1'b0;
      par_ld_i = 1'b0;
      chk(done_o == (k == n + 1), "R8", "done timing", int'(done_o), int'(k == n + 1));
      if (k <= n) chk_outs("R9", prev_min, prev_max, prev_fnd, prev_dly);
      else        chk_outs(req, mn, mx, fnd, dly);
      if (k == n + 1) break;
      if (inject && k == 10) start_i = 1'b1;   // R10
      if (inject && k == 20) begin              // R11
        par_ld_i = 1'b1; par_vec_i = '0;
      end
    end
    @(negedge clk);
    chk(done_o == 1'b0, "R9", "done single cycle", int'(done_o), 0);
    chk_outs("R9", mn, mx, fnd, dly);
    prev_min = mn; prev_max = mx; prev_fnd = fnd; prev_dly = dly;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [255:0] v;
    rst_n = 1'b0; start_i = 1'b0; par_ld_i = 1'b0; par_vec_i = '0;
    ser_en_i = 1'b0; ser_bit_i = 1'b0; dflt_i = 8'h00;
    repeat (4) @(negedge clk);
    chk(done_o == 1'b0, "R1", "reset done", int'(done_o), 0);
    chk_outs("R1", -1, -1, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_outs("R1", -1, -1, 0, 0);

    // R3 R4 R6: clean window 40..120 -> 40, 121, delay 40
    v = mkwin(40, 120); par_load(v); run_scan("R6", v, 8'h55, 1'b0);

    // R3 R4: lone 1 and two-bit pulse rejected, single 0 accepted as fall
    v = mkwin(60, 200); v[100] = 1'b0; v[20] = 1'b1; v[25] = 1'b1; v[26] = 1'b1;
    par_load(v); run_scan("R4", v, 8'h11, 1'b0);

    // R5 R7: all zeros -> both missing, default
    v = '0; par_load(v); run_scan("R7", v, 8'hA3, 1'b0);

    // R5 R7: window runs to the top -> no falling edge
    v = mkwin(100, 255); par_load(v); run_scan("R5", v, 8'h3C, 1'b0);

    // R3 R7: window begins at 0 -> no qualified rising edge
    v = mkwin(0, 50); par_load(v); run_scan("R3", v, 8'h07, 1'b0);

    // R3: rising edge at lowest searched index 4
    v = mkwin(4, 30); par_load(v); run_scan("R3", v, 8'h00, 1'b0);

    // R4: falling edge at highest searched index 251
    v = mkwin(200, 250); par_load(v); run_scan("R4", v, 8'h00, 1'b0);

    // R3 R5: window starting past the limit is never examined
    v = mkwin(252, 255); par_load(v); run_scan("R5", v, 8'hFE, 1'b0);

    // R2: serial load of window 10..90 with a lone 1 at 5
    v = mkwin(10, 90); v[5] = 1'b1; ser_load(v); run_scan("R2", v, 8'h01, 1'b0);

    // R2: parallel wins over serial in the same cycle
    v = mkwin(70, 130);
    @(negedge clk); par_ld_i = 1'b1; par_vec_i = v; ser_en_i = 1'b1; ser_bit_i = 1'b1;
    @(negedge clk); par_ld_i = 1'b0; ser_en_i = 1'b0; ser_bit_i = 1'b0;
    run_scan("R2", v, 8'h02, 1'b0);

    // R10 R11: start and load during the scan are ignored
    v = mkwin(30, 80); par_load(v); run_scan("R10", v, 8'h44, 1'b1);

    // R11: vector kept, rescan without reload gives the same result
    run_scan("R11", v, 8'h45, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule